// File: doc/BRIEF.md
# Programmable Three-Port Parallel I/O Controller

This block is a host-attached parallel port controller with three 8-bit ports (A, B and C) and one control register. The host selects a register with a chip select and a 2-bit address, and moves bytes through a synchronous interface that has separate read and write strobes. Each port, and each half of port C, is set as input or output. An output port drives its pins from an output latch and asserts the output enable for those pins. An input port returns its sampled pins on a read.

The control address accepts two command formats, chosen by bit 7 of the written byte. With bit 7 set, the byte is a full mode and direction word, and the controller stores it whole. With bit 7 clear, the byte sets or clears one bit of the port C latch. Only the basic unstrobed mode runs. A request for the strobed or bidirectional mode is stored and read back, and it raises a sticky flag, but the ports keep working as plain inputs and outputs with the directions given.

Top module: `ppi_top`

## Requirements
- R1: After reset the control register reads 0x9B, all three output latches hold 0xFF, every output enable is low, the unsupported-mode flag is low and the read data is 0x00.
- R2: A write with address 0, 1 or 2 stores the byte in the latch of port A, B or C. The addressed port's output pins follow that latch from the next cycle.
- R3: In a mode word, bit 4 sets the direction of port A and bit 1 sets the direction of port B (1 = input, 0 = output). Every output-enable bit of an output port is high, and every one of an input port is low.
- R4: A read of a data port returns the sampled pins for an input port and the output latch for an output port.
- R5: The two halves of port C have separate directions: bit 3 controls pins 7:4 and bit 0 controls pins 3:0. This applies both to the output enables and to the read mux.
- R6: A write to address 3 with bit 7 = 1 stores the whole byte, and a read of address 3 returns the last stored mode word.
- R7: A write to address 3 with bit 7 = 0 copies bit 0 into the port C latch bit whose index is given by bits 3:1. The other port C bits and the control register do not change.
- R8: A mode word with bit 2 set, or with bits 6:5 not equal to 00, sets the unsupported-mode flag. The flag stays set until reset, including through later mode-0 words.
- R9: Read data is registered. It shows the selected value one cycle after a cycle with chip select and read strobe both high, and it holds its value in every other cycle.
- R10: With chip select low, the write strobe has no effect on any latch, the control register or the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 2 | Register select: 0 = A, 1 = B, 2 = C, 3 = control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| portAIn | input | 8 | Port A pins sampled |
| portBIn | input | 8 | Port B pins sampled |
| portCIn | input | 8 | Port C pins sampled |
| portAOut | output | 8 | Port A output latch |
| portBOut | output | 8 | Port B output latch |
| portCOut | output | 8 | Port C output latch |
| portAOe | output | 8 | Port A output enables |
| portBOe | output | 8 | Port B output enables |
| portCOe | output | 8 | Port C output enables, per pin |
| badMode | output | 1 | Sticky flag for an unsupported mode request |

## Verification
The bench sweeps all 16 direction combinations. For each one it drives pins that are the complement of the latches, so a read mux that returns the wrong source shows up at once, and so does a port C nibble wired to the wrong direction bit. It walks the set/reset command over every bit index with both values. A decoder that gets the index wrong, that disturbs neighbouring bits, or that lets the command overwrite the control register changes an output or the readback. It also tries each mode field value, so a flag that is not sticky, or that decodes the wrong bits, is caught. Writes with chip select low and idle cycles after a read check that nothing leaks through and that the read data holds.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int PPI_W     = 8;
  localparam int PPI_IDX_W = $clog2(PPI_W);
  localparam int PPI_HALF  = PPI_W / 2;

  // control word bit positions
  localparam int CTL_CL_IN  = 0;
  localparam int CTL_B_IN   = 1;
  localparam int CTL_GB_MD  = 2;
  localparam int CTL_CH_IN  = 3;
  localparam int CTL_A_IN   = 4;
  localparam int CTL_GA_LO  = 5;
  localparam int CTL_GA_HI  = 6;
  localparam int CTL_CMD    = 7;
  localparam logic [PPI_W-1:0] CTL_RESET = 8'h9B;

  localparam logic [1:0] SEL_A = 2'd0;
  localparam logic [1:0] SEL_B = 2'd1;
  localparam logic [1:0] SEL_C = 2'd2;
  localparam logic [1:0] SEL_K = 2'd3;

  typedef struct packed {
    logic                 wrA;
    logic                 wrB;
    logic                 wrC;
    logic                 modeSet;
    logic                 bitOp;
    logic [PPI_IDX_W-1:0] bitIdx;
    logic                 bitVal;
    logic                 rdEn;
    logic [1:0]           rdSel;
  } ppi_strobe_t;
endpackage

// File: rtl/ppi_ctrl.sv
module ppi_ctrl
  import ppi_pkg::*;
(
  input  logic             cs,
  input  logic             rd,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [PPI_W-1:0] wdata,
  output ppi_strobe_t      st
);
  logic wrHit;
  assign wrHit = cs && wr;

  always_comb begin
    st         = '0;
    st.wrA     = wrHit && (addr == SEL_A);
    st.wrB     = wrHit && (addr == SEL_B);
    st.wrC     = wrHit && (addr == SEL_C);
    st.modeSet = wrHit && (addr == SEL_K) && wdata[CTL_CMD];
    st.bitOp   = wrHit && (addr == SEL_K) && !wdata[CTL_CMD];
    st.bitIdx  = wdata[PPI_IDX_W:1];
    st.bitVal  = wdata[0];
    st.rdEn    = cs && rd;
    st.rdSel   = addr;
  end
endmodule

// File: rtl/ppi_datapath.sv
module ppi_datapath
  import ppi_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ppi_strobe_t      st,
  input  logic [PPI_W-1:0] wdata,
  input  logic [PPI_W-1:0] pinA,
  input  logic [PPI_W-1:0] pinB,
  input  logic [PPI_W-1:0] pinC,
  output logic [PPI_W-1:0] latA,
  output logic [PPI_W-1:0] latB,
  output logic [PPI_W-1:0] latC,
  output logic [PPI_W-1:0] oeA,
  output logic [PPI_W-1:0] oeB,
  output logic [PPI_W-1:0] oeC,
  output logic [PPI_W-1:0] rdataQ,
  output logic             badQ
);
  logic [PPI_W-1:0] ctrlQ;
  logic [PPI_W-1:0] rdMux;
  logic [PPI_W-1:0] cView;
  logic             wantsOther;

  assign wantsOther = wdata[CTL_GB_MD] | wdata[CTL_GA_LO] | wdata[CTL_GA_HI];

  assign oeA = {PPI_W{~ctrlQ[CTL_A_IN]}};
  assign oeB = {PPI_W{~ctrlQ[CTL_B_IN]}};
  assign oeC = {{PPI_HALF{~ctrlQ[CTL_CH_IN]}}, {PPI_HALF{~ctrlQ[CTL_CL_IN]}}};

  // per-half select of port C source
  assign cView = (oeC & latC) | (~oeC & pinC);

  always_comb begin
    unique case (st.rdSel)
      SEL_A:   rdMux = ctrlQ[CTL_A_IN] ? pinA : latA;
      SEL_B:   rdMux = ctrlQ[CTL_B_IN] ? pinB : latB;
      SEL_C:   rdMux = cView;
      default: rdMux = ctrlQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ  <= CTL_RESET;
      latA   <= '1;
      latB   <= '1;
      latC   <= '1;
      badQ   <= 1'b0;
      rdataQ <= '0;
    end else begin
      if (st.wrA) latA <= wdata;
      if (st.wrB) latB <= wdata;
      if (st.wrC) latC <= wdata;
      if (st.bitOp) latC[st.bitIdx] <= st.bitVal;
      if (st.modeSet) begin
        ctrlQ <= wdata;
        if (wantsOther) badQ <= 1'b1;
      end
      if (st.rdEn) rdataQ <= rdMux;
    end
  end
endmodule

// File: rtl/ppi_top.sv
module ppi_top
  import ppi_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cs,
  input  logic             rd,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [PPI_W-1:0] wdata,
  output logic [PPI_W-1:0] rdata,
  input  logic [PPI_W-1:0] portAIn,
  input  logic [PPI_W-1:0] portBIn,
  input  logic [PPI_W-1:0] portCIn,
  output logic [PPI_W-1:0] portAOut,
  output logic [PPI_W-1:0] portBOut,
  output logic [PPI_W-1:0] portCOut,
  output logic [PPI_W-1:0] portAOe,
  output logic [PPI_W-1:0] portBOe,
  output logic [PPI_W-1:0] portCOe,
  output logic             badMode
);
  ppi_strobe_t st;

  ppi_ctrl u_ctrl (
    .cs(cs), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata), .st(st)
  );

  ppi_datapath u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wdata(wdata),
    .pinA(portAIn), .pinB(portBIn), .pinC(portCIn),
    .latA(portAOut), .latB(portBOut), .latC(portCOut),
    .oeA(portAOe), .oeB(portBOe), .oeC(portCOe),
    .rdataQ(rdata), .badQ(badMode)
  );
endmodule

// File: rtl/ppi_chk.sv
module ppi_chk
  import ppi_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             cs,
  input logic             rd,
  input logic             wr,
  input logic [1:0]       addr,
  input logic [PPI_W-1:0] wdata,
  input logic [PPI_W-1:0] rdata,
  input logic [PPI_W-1:0] portAOut,
  input logic [PPI_W-1:0] portBOut,
  input logic [PPI_W-1:0] portCOut,
  input logic [PPI_W-1:0] portAOe,
  input logic [PPI_W-1:0] portBOe,
  input logic [PPI_W-1:0] portCOe,
  input logic             badMode
);
  // R2
  a_wr_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    cs && wr && addr == SEL_A |=> portAOut == $past(wdata));

  // R3
  dir_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    cs && wr && addr == SEL_K && wdata[CTL_CMD]
    |=> portAOe == {PPI_W{~$past(wdata[CTL_A_IN])}} && portBOe == {PPI_W{~$past(wdata[CTL_B_IN])}});

  // R7
  bit_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    cs && wr && addr == SEL_K && !wdata[CTL_CMD]
    |=> portCOut[$past(wdata[PPI_IDX_W:1])] == $past(wdata[0])
        && $stable(portAOe) && $stable(portBOe) && $stable(portCOe));

  // R8
  bad_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    cs && wr && addr == SEL_K && wdata[CTL_CMD] && (wdata[CTL_GB_MD] || wdata[CTL_GA_HI:CTL_GA_LO] != 2'b00)
    |=> badMode);

  // R8
  bad_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    badMode |=> badMode);

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cs && rd) |=> $stable(rdata));

  // R10
  no_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cs |=> $stable(portAOut) && $stable(portBOut) && $stable(portCOut)
            && $stable(portCOe) && $stable(badMode));
endmodule

bind ppi_top ppi_chk u_chk (
  .clk(clk), .rstN(rstN), .cs(cs), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
  .rdata(rdata), .portAOut(portAOut), .portBOut(portBOut), .portCOut(portCOut),
  .portAOe(portAOe), .portBOe(portBOe), .portCOe(portCOe), .badMode(badMode)
);

// File: tb/ppi_top_bench.sv
module ppi_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [7:0] pinA = 8'd0, pinB = 8'd0, pinC = 8'd0;
  logic [7:0] outA, outB, outC, oeA, oeB, oeC;
  logic badMode;

  int tests = 0;
  int fails = 0;
  logic finished = 1'b0;

  // model state
  logic [7:0] mCtrl, mA, mB, mC;
  logic mBad;

  always #5 clk = ~clk;

  ppi_top u_ppi_top (
    .clk(clk), .rstN(rstN), .cs(cs), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .portAIn(pinA), .portBIn(pinB), .portCIn(pinC),
    .portAOut(outA), .portBOut(outB), .portCOut(outC),
    .portAOe(oeA), .portBOe(oeB), .portCOe(oeC), .badMode(badMode)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d, input logic sel);
    @(negedge clk);
    cs = sel; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
    if (sel) begin
      if (a == 2'd0) mA = d;
      else if (a == 2'd1) mB = d;
      else if (a == 2'd2) mC = d;
      else if (d[7]) begin
        mCtrl = d;
        if (d[2] || d[6:5] != 2'b00) mBad = 1'b1;
      end else mC[d[3:1]] = d[0];
    end
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
    v = rdata;
  endtask

  function automatic logic [7:0] expRead(input logic [1:0] a);
    logic [7:0] cm;
    cm = {{4{mCtrl[3]}}, {4{mCtrl[0]}}};
    case (a)
      2'd0: return mCtrl[4] ? pinA : mA;
      2'd1: return mCtrl[1] ? pinB : mB;
      2'd2: return (cm & pinC) | (~cm & mC);
      default: return mCtrl;
    endcase
  endfunction

  task automatic checkPins(input string req);
    check({req, " oeA"}, oeA, {8{~mCtrl[4]}});
    check({req, " oeB"}, oeB, {8{~mCtrl[1]}});
    check({req, " oeC"}, oeC, {{4{~mCtrl[3]}}, {4{~mCtrl[0]}}});
    check({req, " outA"}, outA, mA);
    check({req, " outB"}, outB, mB);
    check({req, " outC"}, outC, mC);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, held;
    mCtrl = 8'h9B; mA = 8'hFF; mB = 8'hFF; mC = 8'hFF; mBad = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", rdata, 8'h00);
    check("R1 bad", {7'd0, badMode}, 8'h00);
    checkPins("R1");
    busRead(2'd3, v); check("R1 ctrl", v, 8'h9B);

    // R2 R3 R4 R5 R6 sweep of all direction combinations
    for (int i = 0; i < 16; i++) begin
      logic [7:0] mw;
      mw = 8'h80 | {3'b000, i[3], i[2], 1'b0, i[1], i[0]};
      busWrite(2'd3, mw, 1'b1);
      busWrite(2'd0, 8'h11 * i[3:0], 1'b1);
      busWrite(2'd1, 8'hA5 ^ i[7:0], 1'b1);
      busWrite(2'd2, 8'h3C + i[7:0], 1'b1);
      pinA = ~mA; pinB = ~mB; pinC = ~mC;
      checkPins("R3 R5 R2");
      for (int a = 0; a < 4; a++) begin
        busRead(a[1:0], v);
        check(a == 3 ? "R6 ctrl readback" : (a == 2 ? "R5 port C read" : "R4 port read"),
              v, expRead(a[1:0]));
      end
    end
    check("R8 mode0 only", {7'd0, badMode}, 8'h00);

    // R7 bit set/reset walk, port C output
    busWrite(2'd3, 8'h80, 1'b1);
    busWrite(2'd2, 8'h5A, 1'b1);
    for (int b = 0; b < 8; b++) begin
      for (int s = 0; s < 2; s++) begin
        busWrite(2'd3, {4'b0000, b[2:0], s[0]}, 1'b1);
        check("R7 bit op outC", outC, mC);
        check("R7 oeC", oeC, 8'hFF);
      end
    end
    busWrite(2'd3, 8'h0F, 1'b1);
    check("R7 set bit7", outC, mC);
    busRead(2'd2, v); check("R7 readback", v, mC);
    busRead(2'd3, v); check("R7 ctrl kept", v, 8'h80);

    // R10 writes without chip select
    for (int a = 0; a < 4; a++) begin
      busWrite(a[1:0], 8'hE4, 1'b0);
      checkPins("R10");
    end
    busWrite(2'd3, 8'hE0, 1'b0);
    check("R10 bad", {7'd0, badMode}, 8'h00);

    // R9 registered, held read data
    busRead(2'd0, held);
    repeat (3) @(negedge clk);
    busWrite(2'd0, ~held, 1'b1);
    check("R9 hold", rdata, held);

    // R8 each mode field value
    for (int m = 0; m < 8; m++) begin
      busWrite(2'd3, 8'h80 | {1'b0, m[2:1], 2'b00, m[0], 2'b00}, 1'b1);
      check("R8 flag", {7'd0, badMode}, {7'd0, mBad});
      busRead(2'd3, v); check("R6 mode readback", v, mCtrl);
      busWrite(2'd3, 8'h9B, 1'b1);
      check("R8 sticky", {7'd0, badMode}, {7'd0, mBad});
      checkPins("R3 after mode");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule